// File: doc/BRIEF.md
# Converter Sample Averager and Result Formatter

This block sits behind a 12-bit sampling converter and turns its raw samples into 16-bit result words for one channel at a time. Depending on a 3-bit processing mode, it either forwards each sample as a result of its own or sums a programmable number of consecutive samples and releases the sum as a single result. In both cases a programmable right shift scales the value, and the scaled value is then packed into the result word: right-aligned with zero or sign fill, or left-aligned with a clear low nibble.

The channel settings (mode, count, shift, alignment, signedness) are sampled when the first sample of a burst arrives and are held until that burst is dumped, so the sequencer may reprogram them for the next channel while a burst is still open. The block raises a request while a burst is open and more samples are needed.

Top module: `adc_post_proc`

## Requirements
- R1: After reset `res_valid_o`, `res_data_o` and `smp_req_o` are all 0.
- R2: In modes 0 (none), 3 (range only), 4 (range then pulse) and the reserved values 5 to 7, every accepted sample yields one result, with `res_valid_o` high in the clock cycle after the sample; back-to-back samples yield back-to-back results.
- R3: In modes 1 (average) and 2 (average then range), `count_i + 1` accepted samples are summed into a 20-bit accumulator; `res_valid_o` pulses for exactly one cycle, in the cycle after the last sample; `smp_req_o` is high while at least one and fewer than `count_i + 1` samples have been taken and is 0 in the result cycle.
- R4: The sum is shifted right by `shift_i[3:0]`, saturated at 12; `shift_i[4]` has no effect.
- R5: With `left_align_i` = 0 and `signed_i` = 0, `res_data_o` is the low 16 bits of the shifted value.
- R6: With `left_align_i` = 0 and `signed_i` = 1, `res_data_o[11:0]` holds the low 12 bits of the shifted value and bits [15:12] copy its bit 11.
- R7: With `left_align_i` = 1, `res_data_o[15:4]` holds the low 12 bits of the shifted value and `res_data_o[3:0]` is 0; higher bits are dropped.
- R8: Settings are captured with the first sample of a burst; changes to any setting input during an open burst have no effect on that burst's result, and apply from the next burst.
- R9: Cycles with `smp_valid_i` = 0 neither add to the sum nor end a burst; an open burst keeps `smp_req_o` high across them.
- R10: A 256-sample burst of full-scale samples (sum 1048320) does not overflow the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Processing mode: 0 none, 1 average, 2 average then range, 3 range, 4 range then pulse, 5-7 reserved |
| count_i | input | 8 | Samples per averaging burst, minus one |
| shift_i | input | 5 | Right shift; bits [3:0] used, saturates at 12 |
| left_align_i | input | 1 | 1: left-align into [15:4] |
| signed_i | input | 1 | 1: sign-fill bits [15:12] when right-aligned |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 12 | Converter sample |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 16 | Formatted result |
| smp_req_o | output | 1 | Burst open, more samples needed |

## Verification
The bench builds the block with its default parameters: 12-bit samples, an 8-bit count field and a 20-bit accumulator. With these values a single full-scale burst of 256 samples reaches the top of the accumulator, and 32-sample bursts produce sums wider than 16 bits, so truncation in both alignments and the saturating shift at 12 are all reachable with short bursts.

// File: rtl/adc_post_pkg.sv
package adc_post_pkg;
  localparam int DATA_W    = 12;
  localparam int CNT_W     = 8;
  localparam int ACC_W     = DATA_W + CNT_W;
  localparam int RES_W     = 16;
  localparam int SHIFT_W   = 5;
  localparam int SHIFT_MAX = 12;

  typedef enum logic [2:0] {
    MODE_NONE      = 3'd0,
    MODE_AVG       = 3'd1,
    MODE_AVG_RANGE = 3'd2,
    MODE_RANGE     = 3'd3,
    MODE_RANGE_PLS = 3'd4
  } mode_e;

  typedef struct packed {
    logic [2:0]         mode;
    logic [CNT_W-1:0]   count;
    logic [SHIFT_W-1:0] shift;
    logic               left;
    logic               sgn;
  } cfg_t;
endpackage

// File: rtl/adc_acc.sv
module adc_acc
  import adc_post_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  cfg_t              cfg_i,
  output logic              dump_vld_o,
  output logic [ACC_W-1:0]  dump_sum_o,
  output cfg_t              dump_cfg_o,
  output logic              busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;
  cfg_t             lat_q;
  cfg_t             burst_cfg;
  logic             avg_mode;
  logic [CNT_W-1:0] tgt;
  logic             is_last;
  logic [ACC_W-1:0] sum_nxt;

  assign busy_o    = (cnt_q != '0);
  // settings live until the first sample, then frozen
  assign burst_cfg = busy_o ? lat_q : cfg_i;
  assign avg_mode  = (burst_cfg.mode == MODE_AVG) || (burst_cfg.mode == MODE_AVG_RANGE);
  assign tgt       = avg_mode ? burst_cfg.count : '0;
  assign is_last   = (cnt_q == tgt);
  assign sum_nxt   = (busy_o ? acc_q : '0) + ACC_W'(smp_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      acc_q      <= '0;
      lat_q      <= '0;
      dump_vld_o <= 1'b0;
      dump_sum_o <= '0;
      dump_cfg_o <= '0;
    end else begin
      dump_vld_o <= smp_valid_i && is_last;
      if (smp_valid_i) begin
        if (!busy_o) lat_q <= cfg_i;
        if (is_last) begin
          cnt_q      <= '0;
          acc_q      <= '0;
          dump_sum_o <= sum_nxt;
          dump_cfg_o <= burst_cfg;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          acc_q <= sum_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/adc_shift.sv
module adc_shift
  import adc_post_pkg::*;
(
  input  logic [ACC_W-1:0]   sum_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [RES_W-1:0]   val_o
);
  localparam logic [3:0] SAT = 4'(SHIFT_MAX);
  logic [3:0]       amt;
  logic [ACC_W-1:0] shifted;

  // bit 4 ignored, codes above SAT clamp
  assign amt     = (shift_i[3:0] > SAT) ? SAT : shift_i[3:0];
  assign shifted = sum_i >> amt;
  assign val_o   = shifted[RES_W-1:0];
endmodule

// File: rtl/adc_fmt.sv
module adc_fmt
  import adc_post_pkg::*;
(
  input  logic [RES_W-1:0] val_i,
  input  logic             left_i,
  input  logic             sgn_i,
  output logic [RES_W-1:0] word_o
);
  localparam int PAD = RES_W - DATA_W;

  always_comb begin
    if (left_i)     word_o = {val_i[DATA_W-1:0], {PAD{1'b0}}};
    else if (sgn_i) word_o = {{PAD{val_i[DATA_W-1]}}, val_i[DATA_W-1:0]};
    else            word_o = val_i;
  end
endmodule

// File: rtl/adc_post_proc.sv
module adc_post_proc
  import adc_post_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         mode_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               left_align_i,
  input  logic               signed_i,
  input  logic               smp_valid_i,
  input  logic [DATA_W-1:0]  smp_data_i,
  output logic               res_valid_o,
  output logic [RES_W-1:0]   res_data_o,
  output logic               smp_req_o
);
  cfg_t             live_cfg;
  cfg_t             dump_cfg_q;
  logic [ACC_W-1:0] dump_sum_q;
  logic [RES_W-1:0] scaled;

  assign live_cfg = '{mode: mode_i, count: count_i, shift: shift_i,
                      left: left_align_i, sgn: signed_i};

  adc_acc u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .cfg_i       (live_cfg),
    .dump_vld_o  (res_valid_o),
    .dump_sum_o  (dump_sum_q),
    .dump_cfg_o  (dump_cfg_q),
    .busy_o      (smp_req_o)
  );

  adc_shift u_shift (
    .sum_i   (dump_sum_q),
    .shift_i (dump_cfg_q.shift),
    .val_o   (scaled)
  );

  adc_fmt u_fmt (
    .val_i  (scaled),
    .left_i (dump_cfg_q.left),
    .sgn_i  (dump_cfg_q.sgn),
    .word_o (res_data_o)
  );
endmodule

// File: rtl/adc_post_proc_chk.sv
module adc_post_proc_chk
  import adc_post_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic             res_valid_o,
  input logic [RES_W-1:0] res_data_o,
  input logic             smp_req_o,
  input cfg_t             dump_cfg_q
);
  localparam int PAD = RES_W - DATA_W;

  AST_RES_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(smp_valid_i)); // R2
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !smp_req_o); // R3
  AST_SHIFT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && dump_cfg_q.shift[3:0] >= 4'(SHIFT_MAX) && !dump_cfg_q.left && !dump_cfg_q.sgn)
      |-> (res_data_o[RES_W-1:ACC_W-SHIFT_MAX] == '0)); // R4
  AST_SIGN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !dump_cfg_q.left && dump_cfg_q.sgn)
      |-> (res_data_o[RES_W-1:DATA_W] == {PAD{res_data_o[DATA_W-1]}})); // R6
  AST_LEFT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && dump_cfg_q.left) |-> (res_data_o[PAD-1:0] == '0)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_req_o && !smp_valid_i) |=> smp_req_o); // R9
endmodule

bind adc_post_proc adc_post_proc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .res_valid_o (res_valid_o),
  .res_data_o  (res_data_o),
  .smp_req_o   (smp_req_o),
  .dump_cfg_q  (dump_cfg_q)
);

// File: tb/tb_adc_post_proc.sv
`timescale 1ns/1ps
module tb_adc_post_proc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  count = '0;
  logic [4:0]  shift = '0;
  logic        left = 1'b0;
  logic        sgn = 1'b0;
  logic        sv = 1'b0;
  logic [11:0] sd = '0;
  logic        rv;
  logic [15:0] rd;
  logic        req;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  adc_post_proc dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .count_i(count), .shift_i(shift),
    .left_align_i(left), .signed_i(sgn), .smp_valid_i(sv), .smp_data_i(sd),
    .res_valid_o(rv), .res_data_o(rd), .smp_req_o(req));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input int sum, input logic [4:0] sh,
                                        input bit l, input bit s);
    int amt = (sh[3:0] > 12) ? 12 : int'(sh[3:0]);
    logic [15:0] v = 16'((sum >> amt) & 32'hFFFF);
    if (l) return {v[11:0], 4'h0};
    if (s) return {{4{v[11]}}, v[11:0]};
    return v;
  endfunction

  task automatic setcfg(input logic [2:0] m, input logic [7:0] c, input logic [4:0] s,
                        input bit l, input bit g);
    mode = m; count = c; shift = s; left = l; sgn = g;
  endtask

  // n equal samples back to back, then check result and one-cycle pulse
  task automatic burst(input int n, input logic [11:0] val, input logic [15:0] exp,
                       input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(rv == 1'b0, {tag, " R3 no early result"}, rv, 0);
        chk(req == 1'b1, {tag, " R3 req mid-burst"}, req, 1);
      end
      sv = 1'b1; sd = val;
    end
    @(negedge clk);
    sv = 1'b0;
    chk(rv == 1'b1, {tag, " valid"}, rv, 1);
    chk(rd == exp, {tag, " data"}, rd, exp);
    chk(req == 1'b0, {tag, " R3 req cleared"}, req, 0);
    @(negedge clk);
    chk(rv == 1'b0, {tag, " R3 single pulse"}, rv, 0);
  endtask

  task automatic t_reset();
    chk(rv == 1'b0, "R1 valid", rv, 0);
    chk(rd == 16'h0, "R1 data", rd, 0);
    chk(req == 1'b0, "R1 req", req, 0);
  endtask

  task automatic t_pass();
    setcfg(3'd0, 8'd9, 5'd0, 0, 0);
    burst(1, 12'hABC, 16'h0ABC, "R2 mode0");
    setcfg(3'd3, 8'd9, 5'd4, 0, 0);
    burst(1, 12'h123, 16'h0012, "R2 mode3");
    setcfg(3'd4, 8'd9, 5'd0, 0, 0);
    burst(1, 12'h456, 16'h0456, "R2 mode4");
    setcfg(3'd7, 8'd9, 5'd0, 0, 0);
    burst(1, 12'h789, 16'h0789, "R2 reserved");
    // back-to-back singles
    setcfg(3'd0, 8'd0, 5'd0, 0, 0);
    @(negedge clk); sv = 1'b1; sd = 12'h111;
    @(negedge clk); sd = 12'h222;
    chk(rv && rd == 16'h0111, "R2 b2b first", rd, 16'h0111);
    @(negedge clk); sv = 1'b0;
    chk(rv && rd == 16'h0222, "R2 b2b second", rd, 16'h0222);
    @(negedge clk);
  endtask

  task automatic t_avg();
    setcfg(3'd1, 8'd3, 5'd2, 0, 0);
    burst(4, 12'h100, model(4 * 'h100, 5'd2, 0, 0), "R3 avg4");
    setcfg(3'd2, 8'd1, 5'd0, 0, 0);
    burst(2, 12'hFFF, model(2 * 'hFFF, 5'd0, 0, 0), "R3 avgrange2");
  endtask

  task automatic t_shift();
    setcfg(3'd1, 8'd15, 5'd15, 0, 0);
    burst(16, 12'hFFF, 16'h000F, "R4 sat15");
    setcfg(3'd1, 8'd15, 5'd12, 0, 0);
    burst(16, 12'hFFF, 16'h000F, "R4 at12");
    setcfg(3'd1, 8'd15, 5'b10010, 0, 0);
    burst(16, 12'hFFF, model(16 * 'hFFF, 5'd2, 0, 0), "R4 bit4 ignored");
  endtask

  task automatic t_fmt();
    setcfg(3'd1, 8'd31, 5'd0, 0, 0);
    burst(32, 12'hFFF, 16'hFFE0, "R5 truncate");
    setcfg(3'd0, 8'd0, 5'd0, 0, 1);
    burst(1, 12'h800, 16'hF800, "R6 negative");
    burst(1, 12'h7FF, 16'h07FF, "R6 positive");
    setcfg(3'd0, 8'd0, 5'd0, 1, 1);
    burst(1, 12'hABC, 16'hABC0, "R7 left");
    setcfg(3'd1, 8'd31, 5'd0, 1, 0);
    burst(32, 12'hFFF, 16'hFE00, "R7 drop high");
  endtask

  task automatic t_cfg_hold();
    setcfg(3'd1, 8'd2, 5'd0, 0, 0);
    @(negedge clk); sv = 1'b1; sd = 12'h010;
    @(negedge clk); sd = 12'h020;
    setcfg(3'd0, 8'd0, 5'd3, 1, 1);
    @(negedge clk); sd = 12'h030;
    chk(rv == 1'b0, "R8 burst not cut", rv, 0);
    @(negedge clk); sv = 1'b0;
    chk(rv && rd == 16'h0060, "R8 old cfg kept", rd, 16'h0060);
    burst(1, 12'h080, 16'h0100, "R8 new cfg next burst");
  endtask

  task automatic t_gaps();
    setcfg(3'd1, 8'd1, 5'd0, 0, 0);
    @(negedge clk); sv = 1'b1; sd = 12'h300;
    @(negedge clk); sv = 1'b0; sd = 12'hFFF;
    repeat (3) begin
      @(negedge clk);
      chk(rv == 1'b0 && req == 1'b1, "R9 idle holds burst", {rv, req}, 1);
    end
    sv = 1'b1; sd = 12'h005;
    @(negedge clk); sv = 1'b0;
    chk(rv && rd == 16'h0305, "R9 sum skips idle", rd, 16'h0305);
  endtask

  task automatic t_full();
    setcfg(3'd1, 8'd255, 5'd12, 0, 0);
    burst(256, 12'hFFF, 16'h00FF, "R10 full 256 shift12");
    setcfg(3'd1, 8'd255, 5'd5, 0, 0);
    burst(256, 12'hFFF, model(256 * 'hFFF, 5'd5, 0, 0), "R10 full 256 shift5");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_avg();
    t_shift();
    t_fmt();
    t_cfg_hold();
    t_gaps();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule